// File: doc/BRIEF.md
# Bank Workload Reallocation Steering

This block steers request traffic from a router into a set of sibling banks. While one bank is taken out of service for testing, its traffic is folded onto a chosen helper bank. The helper keeps serving its own traffic as well. When the test ends, the traffic is handed back to the original bank. Both changeovers follow a fixed order of hold, drain, move and remap. A request is never dropped during a changeover. It is held back with backpressure on the request port until it may go to the right bank.

Each request is homed by the low address bits, which select one of the banks. In normal service every request goes to its home bank. A changeover is started with a start pulse that names the bank to test and the helper. The block then moves through these states:

- `ST_IDLE` → `ST_PRE_STALL` on a valid start.
- `ST_PRE_STALL` → `ST_PRE_DRAIN` after one cycle.
- `ST_PRE_DRAIN` → `ST_PRE_MOVE` once the tested bank has no outstanding requests.
- `ST_PRE_MOVE` → `ST_REMAP` when the banks report that the state move is done.
- `ST_REMAP` → `ST_POST_STALL` on the finish pulse.
- `ST_POST_STALL` → `ST_POST_DRAIN` after one cycle.
- `ST_POST_DRAIN` → `ST_POST_MOVE` once the helper has no outstanding requests.
- `ST_POST_MOVE` → `ST_IDLE` when the move back is done.

During `ST_PRE_MOVE` the tested bank passes its dirty entries to the helper and invalidates its clean ones. Requests that the helper receives on behalf of the absent bank carry a marker bit. The helper stores this bit with the entries it allocates for them. In `ST_POST_MOVE` the roles swap: the helper hands back or flushes every marked entry before the home mapping is restored.

Top module: `bank_steer`

## Requirements
- R1: After reset the block is in `ST_IDLE`: `move_req` and `test_grant` are 0 and every request goes to its home bank.
- R2: In `ST_IDLE`, a request with home bank h = `in_addr[BW-1:0]` raises only `bank_valid[h]`, with `bank_mark`=0 and `in_ready` = `bank_ready[h]`.
- R3: A `test_start` pulse is acted on only in `ST_IDLE` and only when `test_bank` differs from `helper_bank`. Any other start pulse leaves state and routing unchanged.
- R4: From the cycle after an accepted start until the remap, requests homed to the tested bank are held: `in_ready`=0 and no `bank_valid` is raised. Requests homed to other banks are routed normally.
- R5: `move_req` for the forward move is not raised until the tested bank's outstanding count is zero. The outstanding count is handshakes to that bank minus `bank_cpl` pulses from it.
- R6: In `ST_PRE_MOVE`, `move_req`=1 with `move_src`=tested bank, `move_dst`=helper and `move_marked`=0, held until `move_done`. The next cycle enters `ST_REMAP`.
- R7: In `ST_REMAP`, `test_grant`=1. Requests homed to the tested bank go to the helper with `bank_mark`=1. Requests homed to the helper go to the helper with `bank_mark`=0. The tested bank receives nothing.
- R8: A `test_finish` pulse in `ST_REMAP` starts the return. Requests homed to either bank are held, and the helper is drained to zero outstanding. Then `move_req`=1 with `move_src`=helper, `move_dst`=tested bank and `move_marked`=1, held until `move_done`. After that the block is back in `ST_IDLE` with home routing.
- R9: Every accepted request (`in_valid` and `in_ready`) is delivered to exactly one bank in the same cycle, with its address and data unchanged. No bank sees a request that was not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_start | input | 1 | Pulse: begin taking `test_bank` out of service |
| test_bank | input | BW | Bank to be tested, sampled with `test_start` |
| helper_bank | input | BW | Bank that absorbs the tested bank's traffic |
| test_finish | input | 1 | Pulse: test complete, return traffic |
| test_grant | output | 1 | Tested bank is isolated and may be tested |
| in_valid | input | 1 | Request from router valid |
| in_addr | input | AW | Request address; low BW bits select the home bank |
| in_data | input | DW | Request payload |
| in_ready | output | 1 | Request accepted this cycle when high with `in_valid` |
| bank_valid | output | NB | One-hot request valid per bank |
| bank_ready | input | NB | Per-bank ready |
| bank_addr | output | AW | Request address to banks |
| bank_data | output | DW | Request payload to banks |
| bank_mark | output | 1 | Request belongs to the absent bank (reallocated) |
| bank_cpl | input | NB | Per-bank completion pulse, one per finished request |
| move_req | output | 1 | State move requested |
| move_src | output | BW | Bank giving up state |
| move_dst | output | BW | Bank receiving state |
| move_marked | output | 1 | Move only marker-tagged entries (return direction) |
| move_done | input | 1 | State move finished |

## Verification
Requests are issued with random addresses across whole changeovers, which exercises holding, passing and redirection at once. Separate sessions then send traffic homed only to the tested bank or only to the helper. Tested-bank-only traffic separates a correct hold and redirect from a block that merely stalls everything. Helper-only traffic shows that the helper's own requests keep flowing in the forward direction and are held only on the return. Start pulses with equal banks, or given mid-session, are mixed in to show they change nothing. Payloads carry a running sequence number, so a lost, duplicated or misrouted request shows up in the cycle it happens.

// File: rtl/bsteer_pkg.sv
package bsteer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_STALL,
        ST_PRE_DRAIN,
        ST_PRE_MOVE,
        ST_REMAP,
        ST_POST_STALL,
        ST_POST_DRAIN,
        ST_POST_MOVE
    } steer_state_e;

endpackage

// File: rtl/bsteer_route.sv
// Combinational steering of one request onto a bank.
module bsteer_route #(
    parameter int NB = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic          in_valid,
    input  logic [BW-1:0] home,
    input  logic          remap_on,
    input  logic          hold_tst,
    input  logic          hold_hlp,
    input  logic [BW-1:0] tst,
    input  logic [BW-1:0] hlp,
    input  logic [NB-1:0] bank_ready,
    output logic          in_ready,
    output logic [NB-1:0] bank_valid,
    output logic          bank_mark
);

    logic          is_tst;
    logic          is_hlp;
    logic          held;
    logic [BW-1:0] dest;

    always_comb begin
        is_tst    = (home == tst);
        is_hlp    = (home == hlp);
        held      = (hold_tst && is_tst) || (hold_hlp && is_hlp);
        dest      = (remap_on && is_tst) ? hlp : home;
        bank_mark = remap_on && is_tst;
        in_ready  = !held && bank_ready[dest];
    end

    for (genvar b = 0; b < NB; b++) begin : g_vld
        assign bank_valid[b] = in_valid && !held && (dest == BW'(b));
    end

endmodule

// File: rtl/bsteer_outstanding.sv
// Per-bank outstanding request counters.
module bsteer_outstanding #(
    parameter int NB = 4,
    parameter int CW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NB-1:0]          issue,
    input  logic [NB-1:0]          cpl,
    output logic [NB-1:0][CW-1:0]  cnt
);

    for (genvar b = 0; b < NB; b++) begin : g_cnt
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                unique case ({issue[b], cpl[b]})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
        assign cnt[b] = cnt_q;
    end

endmodule

// File: rtl/bsteer_seq.sv
// Changeover sequencer: hold, drain, move, remap and the reverse.
module bsteer_seq
    import bsteer_pkg::*;
#(
    parameter int NB = 4,
    parameter int CW = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [BW-1:0]          tst_in,
    input  logic [BW-1:0]          hlp_in,
    input  logic                   finish,
    input  logic                   move_done,
    input  logic [NB-1:0][CW-1:0]  cnt,
    output logic [BW-1:0]          tst_q,
    output logic [BW-1:0]          hlp_q,
    output logic                   remap_on,
    output logic                   hold_tst,
    output logic                   hold_hlp,
    output logic                   move_req,
    output logic [BW-1:0]          move_src,
    output logic [BW-1:0]          move_dst,
    output logic                   move_marked,
    output logic                   test_grant
);

    steer_state_e state_q;
    steer_state_e state_d;
    logic         tst_idle;
    logic         hlp_idle;

    assign tst_idle = (cnt[tst_q] == '0);
    assign hlp_idle = (cnt[hlp_q] == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start && (tst_in != hlp_in)) state_d = ST_PRE_STALL;
            ST_PRE_STALL:  state_d = ST_PRE_DRAIN;
            ST_PRE_DRAIN:  if (tst_idle) state_d = ST_PRE_MOVE;
            ST_PRE_MOVE:   if (move_done) state_d = ST_REMAP;
            ST_REMAP:      if (finish) state_d = ST_POST_STALL;
            ST_POST_STALL: state_d = ST_POST_DRAIN;
            ST_POST_DRAIN: if (hlp_idle) state_d = ST_POST_MOVE;
            ST_POST_MOVE:  if (move_done) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tst_q   <= '0;
            hlp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start && (tst_in != hlp_in)) begin
                tst_q <= tst_in;
                hlp_q <= hlp_in;
            end
        end
    end

    always_comb begin
        remap_on    = 1'b0;
        hold_tst    = 1'b0;
        hold_hlp    = 1'b0;
        move_req    = 1'b0;
        move_src    = tst_q;
        move_dst    = hlp_q;
        move_marked = 1'b0;
        test_grant  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PRE_STALL, ST_PRE_DRAIN: begin
                hold_tst = 1'b1;
            end
            ST_PRE_MOVE: begin
                hold_tst = 1'b1;
                move_req = 1'b1;
            end
            ST_REMAP: begin
                remap_on   = 1'b1;
                test_grant = 1'b1;
            end
            ST_POST_STALL, ST_POST_DRAIN: begin
                remap_on = 1'b1;
                hold_tst = 1'b1;
                hold_hlp = 1'b1;
            end
            ST_POST_MOVE: begin
                remap_on    = 1'b1;
                hold_tst    = 1'b1;
                hold_hlp    = 1'b1;
                move_req    = 1'b1;
                move_src    = hlp_q;
                move_dst    = tst_q;
                move_marked = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bank_steer.sv
module bank_steer #(
    parameter int NB = 4,
    parameter int AW = 12,
    parameter int DW = 16,
    parameter int CW = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_start,
    input  logic [BW-1:0] test_bank,
    input  logic [BW-1:0] helper_bank,
    input  logic          test_finish,
    output logic          test_grant,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic [NB-1:0] bank_valid,
    input  logic [NB-1:0] bank_ready,
    output logic [AW-1:0] bank_addr,
    output logic [DW-1:0] bank_data,
    output logic          bank_mark,
    input  logic [NB-1:0] bank_cpl,
    output logic          move_req,
    output logic [BW-1:0] move_src,
    output logic [BW-1:0] move_dst,
    output logic          move_marked,
    input  logic          move_done
);

    logic [NB-1:0][CW-1:0] cnt_q;
    logic [BW-1:0]         tst_q;
    logic [BW-1:0]         hlp_q;
    logic                  remap_on;
    logic                  hold_tst;
    logic                  hold_hlp;

    assign bank_addr = in_addr;
    assign bank_data = in_data;

    bsteer_seq #(.NB(NB), .CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (test_start),
        .tst_in      (test_bank),
        .hlp_in      (helper_bank),
        .finish      (test_finish),
        .move_done   (move_done),
        .cnt         (cnt_q),
        .tst_q       (tst_q),
        .hlp_q       (hlp_q),
        .remap_on    (remap_on),
        .hold_tst    (hold_tst),
        .hold_hlp    (hold_hlp),
        .move_req    (move_req),
        .move_src    (move_src),
        .move_dst    (move_dst),
        .move_marked (move_marked),
        .test_grant  (test_grant)
    );

    bsteer_route #(.NB(NB)) u_route (
        .in_valid   (in_valid),
        .home       (in_addr[BW-1:0]),
        .remap_on   (remap_on),
        .hold_tst   (hold_tst),
        .hold_hlp   (hold_hlp),
        .tst        (tst_q),
        .hlp        (hlp_q),
        .bank_ready (bank_ready),
        .in_ready   (in_ready),
        .bank_valid (bank_valid),
        .bank_mark  (bank_mark)
    );

    bsteer_outstanding #(.NB(NB), .CW(CW)) u_outs (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (bank_valid & bank_ready),
        .cpl   (bank_cpl),
        .cnt   (cnt_q)
    );

endmodule

// File: rtl/bank_steer_chk.sv
module bank_steer_chk #(
    parameter int NB = 4,
    parameter int CW = 4,
    localparam int BW = $clog2(NB)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [NB-1:0]         bank_valid,
    input logic [NB-1:0]         bank_ready,
    input logic                  move_req,
    input logic                  move_done,
    input logic                  move_marked,
    input logic                  test_grant,
    input logic [BW-1:0]         tst_q,
    input logic [NB-1:0][CW-1:0] cnt
);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_valid)); // R9

    AST_HANDSHAKE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) == (|(bank_valid & bank_ready))); // R9

    AST_MOVE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(move_req) && !move_marked) |-> (cnt[tst_q] == '0)); // R5

    AST_MOVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (move_req && !move_done) |=> move_req); // R6

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_grant && move_req)); // R6

    AST_TESTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        test_grant |-> !bank_valid[tst_q]); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt[tst_q]) && !move_req |=> (cnt[tst_q] != '0)); // R5

endmodule

bind bank_steer bank_steer_chk #(.NB(NB), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .bank_valid  (bank_valid),
    .bank_ready  (bank_ready),
    .move_req    (move_req),
    .move_done   (move_done),
    .move_marked (move_marked),
    .test_grant  (test_grant),
    .tst_q       (tst_q),
    .cnt         (cnt_q)
);

// File: tb/bank_steer_test.sv
module bank_steer_test;
    localparam int NB = 4;
    localparam int BW = 2;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_start = 1'b0;
    logic [BW-1:0] test_bank = '0;
    logic [BW-1:0] helper_bank = '0;
    logic          test_finish = 1'b0;
    logic          test_grant;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic [NB-1:0] bank_valid;
    logic [NB-1:0] bank_ready = '0;
    logic [AW-1:0] bank_addr;
    logic [DW-1:0] bank_data;
    logic          bank_mark;
    logic [NB-1:0] bank_cpl = '0;
    logic          move_req;
    logic [BW-1:0] move_src;
    logic [BW-1:0] move_dst;
    logic          move_marked;
    logic          move_done = 1'b0;

    bank_steer #(.NB(NB), .AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .test_start(test_start), .test_bank(test_bank),
        .helper_bank(helper_bank), .test_finish(test_finish), .test_grant(test_grant),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data), .in_ready(in_ready),
        .bank_valid(bank_valid), .bank_ready(bank_ready), .bank_addr(bank_addr),
        .bank_data(bank_data), .bank_mark(bank_mark), .bank_cpl(bank_cpl),
        .move_req(move_req), .move_src(move_src), .move_dst(move_dst),
        .move_marked(move_marked), .move_done(move_done)
    );

    always #2 clk = ~clk;

    int  checks = 0;
    int  fails = 0;
    bit  reported = 0;
    int  m_state = 0;
    int  m_tst = 0;
    int  m_hlp = 0;
    int  m_cnt[NB];
    int  next_id = 0;
    int  exp_deliv = 0;
    int  addr_mode = 0;
    bit  want_start = 0;
    int  req_tst = 0;
    int  req_hlp = 0;
    bit  want_finish = 0;
    bit  pend = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    endtask

    function automatic string route_tag(input int s);
        if (s == 0) return "R2";
        if (s <= 3) return "R4";
        if (s == 4) return "R7";
        return "R8";
    endfunction

    // One clock of stimulus, comparison and model update.
    task automatic step();
        int  home, dest, ev, er, em, er_mv, es, ed, emk, eg;
        bit  hold_t, hold_h, remap, held, acc;
        bit  [NB-1:0] cpl_v;
        @(negedge clk);
        test_start  = want_start;
        test_bank   = BW'(req_tst);
        helper_bank = BW'(req_hlp);
        want_start  = 0;
        test_finish = want_finish;
        want_finish = 0;
        if (!pend && ($urandom % 10) < 7) begin
            int b;
            pend = 1;
            b = (addr_mode == 1) ? m_tst : (addr_mode == 2) ? m_hlp : int'($urandom % NB);
            in_addr = AW'((($urandom % (1 << AW)) & ~(NB - 1)) | b);
            in_data = DW'(next_id);
        end
        in_valid = pend;
        for (int i = 0; i < NB; i++) begin
            bank_ready[i] = (m_cnt[i] < 12) && (($urandom % 4) != 0);
            cpl_v[i] = (m_cnt[i] > 0) && (($urandom % 3) == 0);
        end
        bank_cpl  = cpl_v;
        move_done = (m_state == 3 || m_state == 7) && (($urandom % 4) == 0);
        #1;
        hold_t = (m_state >= 1 && m_state <= 3) || m_state >= 5;
        hold_h = m_state >= 5;
        remap  = m_state >= 4;
        home   = int'(in_addr[BW-1:0]);
        held   = (hold_t && home == m_tst) || (hold_h && home == m_hlp);
        dest   = (remap && home == m_tst) ? m_hlp : home;
        ev     = (pend && !held) ? (1 << dest) : 0;
        er     = (!held && bank_ready[dest]) ? 1 : 0;
        em     = (remap && home == m_tst) ? 1 : 0;
        chk(int'(bank_valid) == ev, route_tag(m_state), "bank_valid", int'(bank_valid), ev);
        chk(int'(in_ready) == er, route_tag(m_state), "in_ready", int'(in_ready), er);
        if (ev != 0)
            chk(int'(bank_mark) == em, route_tag(m_state), "bank_mark", int'(bank_mark), em);
        er_mv = (m_state == 3 || m_state == 7) ? 1 : 0;
        es    = (m_state == 7) ? m_hlp : m_tst;
        ed    = (m_state == 7) ? m_tst : m_hlp;
        emk   = (m_state == 7) ? 1 : 0;
        eg    = (m_state == 4) ? 1 : 0;
        chk(int'(move_req) == er_mv, (m_state == 2) ? "R5" : (m_state == 7) ? "R8" : "R6",
            "move_req", int'(move_req), er_mv);
        if (er_mv == 1) begin
            chk(int'(move_src) == es && int'(move_dst) == ed,
                (m_state == 7) ? "R8" : "R6", "move_src*4+dst",
                int'(move_src) * 4 + int'(move_dst), es * 4 + ed);
            chk(int'(move_marked) == emk, (m_state == 7) ? "R8" : "R6",
                "move_marked", int'(move_marked), emk);
        end
        chk(int'(test_grant) == eg, (m_state == 4) ? "R7" : "R3", "test_grant",
            int'(test_grant), eg);
        if ((bank_valid & bank_ready) != 0) begin
            // R9: delivered request is the one offered, exactly once
            chk(int'(bank_data) == exp_deliv && bank_addr == in_addr, "R9",
                "delivered id", int'(bank_data), exp_deliv);
            exp_deliv++;
        end
        acc = pend && (er == 1);
        @(posedge clk);
        case (m_state)
            0: if (test_start && req_tst != req_hlp) begin
                   m_tst = req_tst; m_hlp = req_hlp; m_state = 1;
               end
            1: m_state = 2;
            2: if (m_cnt[m_tst] == 0) m_state = 3;
            3: if (move_done) m_state = 4;
            4: if (test_finish) m_state = 5;
            5: m_state = 6;
            6: if (m_cnt[m_hlp] == 0) m_state = 7;
            7: if (move_done) m_state = 0;
            default: m_state = 0;
        endcase
        if (acc) begin
            m_cnt[dest]++;
            pend = 0;
            next_id++;
        end
        for (int i = 0; i < NB; i++) if (cpl_v[i]) m_cnt[i]--;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_state(input int s);
        int k = 0;
        while (m_state != s && k < 3000) begin step(); k++; end
        chk(m_state == s, "R8", "reached state", m_state, s);
    endtask

    task automatic session(input int t, input int h, input int mode);
        addr_mode = mode;
        req_tst = t; req_hlp = h; want_start = 1;
        run(3);
        // R4: requests homed to the tested bank are held before remap
        chk(m_state >= 1, "R4", "session started", m_state, 1);
        wait_state(4);
        run(60);
        // R3: a start pulse mid-session changes nothing
        req_tst = h; req_hlp = t; want_start = 1;
        run(40);
        chk(m_state == 4, "R3", "state after busy start", m_state, 4);
        want_finish = 1;
        run(2);
        wait_state(0);
        run(30);
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "R9", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < NB; i++) m_cnt[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(move_req == 1'b0, "R1", "move_req after reset", int'(move_req), 0);
        chk(test_grant == 1'b0, "R1", "test_grant after reset", int'(test_grant), 0);
        addr_mode = 0;
        run(200);
        // R3: equal banks are rejected
        req_tst = 2; req_hlp = 2; want_start = 1;
        run(20);
        chk(m_state == 0, "R3", "state after equal-bank start", m_state, 0);
        session(1, 2, 0);
        session(3, 0, 1);
        session(0, 3, 2);
        session(2, 1, 0);
        addr_mode = 0;
        while (pend) step();
        run(5);
        chk(exp_deliv == next_id, "R9", "delivered vs accepted", exp_deliv, next_id);
        summary();
    end

endmodule